// File: doc/BRIEF.md
# Buffered 16-bit PWM timer

This block generates a pulse-width-modulated waveform from a free-running up-counter. The counter advances on ticks from a prescaler. The prescaler divides the core clock by one of four powers of two, or it passes through pulses from an external slow-clock strobe. A full period is 2^CNT_W counter steps, which is 65536 at the default width. The pin is in its active state while the counter is below the active width value and inactive for the rest of the period.

Software loads a new width with two byte writes: the low byte first, then the high byte. The high-byte write commits the pair. While the timer runs, the committed pair waits in a holding register and moves into the active compare register only at the period boundary. While the timer is stopped, the pair takes effect at once. The readback port always shows the active value, never the pending one.

Stopping the timer freezes the pin. While stopped, software may drive the pin by writing the polarity bit; the same bit sets the polarity of the waveform after the next start.

Top module: `pwm16_timer`

## Requirements
- R1: After reset, pwm_o is 0, period_irq_o is 0 and width_o is 0.
- R2: While running, period_irq_o pulses high for exactly one cycle each time the counter wraps from all-ones to zero. Consecutive pulses are 2^CNT_W step periods apart.
- R3: The step period is selected by src_sel_i, and codes 5 to 7 stop all counting:

  | src_sel_i | Step period |
  |---|---|
  | 0 | 2^11 clock cycles |
  | 1 | 2^7 clock cycles |
  | 2 | 2^5 clock cycles |
  | 3 | 2^3 clock cycles |
  | 4 | one step per slow_tick_i pulse |
  | 5 to 7 | no counting |

- R4: With polarity bit 0, pwm_o is high for min(width, 2^CNT_W) steps out of every period. A width at or above 2^CNT_W holds the pin high for the whole period.
- R5: While running, a committed width leaves width_o unchanged until the next period interrupt. In the cycle the pulse is seen, width_o shows the new value.
- R6: While stopped, a committed width appears on width_o in the cycle after the high-byte write.
- R7: A width is committed only by a high-byte write that follows a low-byte write. The low byte goes in bits 7:0 and the high byte in bits 15:8. A high-byte write with no pending low byte is ignored. A low-byte write alone changes nothing visible.
- R8: Dropping run_i freezes pwm_o at its current level, and no period interrupt fires while stopped.
- R9: A polarity write while stopped sets pwm_o to the inverse of tff_i in the next cycle. With polarity bit 1, the running waveform is inverted, high for (2^CNT_W - width) steps per period.
- R10: A polarity write while running has no effect on the waveform.
- R11: A high-byte write in the same cycle as a counter wrap becomes pending and transfers at the following wrap, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 = timer counts, 0 = stopped |
| src_sel_i | input | 3 | Step source select (R3) |
| slow_tick_i | input | 1 | One-cycle strobe from the slow clock domain |
| wr_lo_i | input | 1 | Low-byte width write strobe |
| wr_hi_i | input | 1 | High-byte width write strobe |
| wdata_i | input | 8 | Byte write data |
| tff_wr_i | input | 1 | Polarity bit write strobe |
| tff_i | input | 1 | Polarity bit value |
| width_o | output | 16 | Active width readback |
| pwm_o | output | 1 | PWM output pin |
| period_irq_o | output | 1 | Period interrupt pulse |

## Verification
The hardest case to reach is a high-byte write landing on the exact edge where the counter wraps (R11). The bench locks onto an observed interrupt pulse. It then counts one full period minus one cycle, so the low-byte and high-byte strobes are placed on the last two edges before the next wrap. The duty and period checks use a 4-bit counter, so each window is short. That lets every width from 0 to 15 be swept, plus one oversize width, with the expected high time computed as width times the step period.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int unsigned WIDTH_W  = 16;
  localparam int unsigned NUM_FAST = 4;

  typedef enum logic [2:0] {
    SRC_DIV11 = 3'd0,
    SRC_DIV7  = 3'd1,
    SRC_DIV5  = 3'd2,
    SRC_DIV3  = 3'd3,
    SRC_SLOW  = 3'd4
  } src_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm16_pkg::*;
#(
  parameter int unsigned DIV_EXP [NUM_FAST] = '{11, 7, 5, 3},
  parameter int unsigned PRE_W = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       slow_tick_i,
  output logic       tick_o
);
  logic [PRE_W-1:0]    pre_q;
  logic [NUM_FAST-1:0] fast_tick;
  src_sel_e            sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar g = 0; g < NUM_FAST; g++) begin : g_fast
    assign fast_tick[g] = &pre_q[DIV_EXP[g]-1:0];
  end

  assign sel = src_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SRC_DIV11, SRC_DIV7,
      SRC_DIV5,  SRC_DIV3: tick_o = fast_tick[sel_i[1:0]];
      SRC_SLOW:            tick_o = slow_tick_i;
      default:             tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_width_buf.sv
module pwm_width_buf
  import pwm16_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               wrap_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [7:0]         data_i,
  output logic [WIDTH_W-1:0] active_o
);
  logic [7:0]         lo_q;
  logic               lo_vld_q;
  logic [WIDTH_W-1:0] hold_q, act_q;
  logic               pend_q;
  logic               commit;
  logic [WIDTH_W-1:0] pair;

  assign commit = wr_hi_i && lo_vld_q;
  assign pair   = {data_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      lo_vld_q <= 1'b0;
    end else if (wr_lo_i) begin
      lo_q     <= data_i;
      lo_vld_q <= 1'b1;
    end else if (commit) begin
      lo_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else if (!run_i) begin
      // stopped: commit lands straight in the compare register
      if (commit) begin
        hold_q <= pair;
        act_q  <= pair;
      end else if (pend_q) begin
        act_q  <= hold_q;
      end
      pend_q <= 1'b0;
    end else begin
      // running: wrap moves the old pending value; a same-cycle commit waits
      if (wrap_i && pend_q) act_q <= hold_q;
      if (commit) begin
        hold_q <= pair;
        pend_q <= 1'b1;
      end else if (wrap_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               tff_wr_i,
  input  logic               tff_i,
  output logic               wrap_o,
  output logic               irq_o,
  output logic               pin_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [WIDTH_W-1:0] cnt_ext;
  logic               pol_q, pin_q, irq_q;

  assign cnt_ext = WIDTH_W'(cnt_q);
  assign wrap_o  = run_i && tick_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
      pin_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (run_i) begin
      pin_q <= (cnt_ext < width_i) ^ pol_q;
      if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
      irq_q <= wrap_o;
    end else begin
      irq_q <= 1'b0;
      if (tff_wr_i) begin
        pol_q <= tff_i;
        pin_q <= ~tff_i;
      end
    end
  end

  assign irq_o = irq_q;
  assign pin_o = pin_q;
endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
  import pwm16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [2:0]         src_sel_i,
  input  logic               slow_tick_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [7:0]         wdata_i,
  input  logic               tff_wr_i,
  input  logic               tff_i,
  output logic [WIDTH_W-1:0] width_o,
  output logic               pwm_o,
  output logic               period_irq_o
);
  logic tick, wrap;

  pwm_prescaler u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (src_sel_i),
    .slow_tick_i(slow_tick_i),
    .tick_o     (tick)
  );

  pwm_width_buf u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .wrap_i  (wrap),
    .wr_lo_i (wr_lo_i),
    .wr_hi_i (wr_hi_i),
    .data_i  (wdata_i),
    .active_o(width_o)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .tick_i  (tick),
    .width_i (width_o),
    .tff_wr_i(tff_wr_i),
    .tff_i   (tff_i),
    .wrap_o  (wrap),
    .irq_o   (period_irq_o),
    .pin_o   (pwm_o)
  );
endmodule

// File: rtl/pwm16_timer_chk.sv
module pwm16_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic [2:0]  src_sel_i,
  input logic        slow_tick_i,
  input logic        wr_lo_i,
  input logic        wr_hi_i,
  input logic [7:0]  wdata_i,
  input logic        tff_wr_i,
  input logic        tff_i,
  input logic [15:0] width_o,
  input logic        pwm_o,
  input logic        period_irq_o
);
  assert_irq_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_irq_o |=> !period_irq_o);

  assert_irq_needs_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_irq_o |-> $past(run_i));

  assert_width_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !period_irq_o) |-> $stable(width_o));

  assert_pin_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && !$past(tff_wr_i)) |-> $stable(pwm_o));

  assert_tff_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_i) && $past(tff_wr_i)) |-> (pwm_o == !$past(tff_i)));
endmodule

bind pwm16_timer pwm16_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pwm16_timer_test.sv
module pwm16_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 4;
  localparam int STEPS      = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [2:0]  src = 3'd3;
  logic        slow_tick = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wdata = 8'd0;
  logic        tff_wr = 1'b0, tff = 1'b0;
  logic [15:0] width;
  logic        pwm, irq;

  int checks = 0;
  int fails  = 0;

  pwm16_timer #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .src_sel_i(src),
    .slow_tick_i(slow_tick), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(wdata), .tff_wr_i(tff_wr), .tff_i(tff),
    .width_o(width), .pwm_o(pwm), .period_irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow strobe: one cycle high every 5 cycles
  initial begin
    forever begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  end

  initial begin
    #(CLK_PERIOD * 195000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_width(input int v);
    @(negedge clk); wr_lo = 1'b1; wdata = 8'(v);
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = 8'(v >> 8);
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 70000);
    if (n >= 70000) check(1'b0, req, 0, 1);
  endtask

  // one full period after an observed pulse: high count and next pulse position
  task automatic measure(input int p, input int exp_hi, input string req);
    int hi = 0;
    int bad_irq = 0;
    bit end_irq = 1'b0;
    wait_irq(req);
    for (int k = 1; k <= p; k++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (k < p && irq) bad_irq++;
      if (k == p) end_irq = irq;
    end
    check(hi == exp_hi, {req, " high time"}, hi, exp_hi);
    check(end_irq && bad_irq == 0, "R2 period", int'(end_irq) - bad_irq, 1);
  endtask

  initial begin
    int held;
    bit p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm == 1'b0, "R1 pwm", int'(pwm), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(width == 16'd0, "R1 width", int'(width), 0);

    // R4/R6 sweep over every width at step period 8
    src = 3'd3;
    for (int w = 0; w < STEPS; w++) begin
      wr_width(w);
      check(width == 16'(w), "R6 stopped load", int'(width), w);
      @(negedge clk); run = 1'b1;
      measure(STEPS * 8, w * 8, "R4");
      @(negedge clk); run = 1'b0;
    end
    wr_width(16'h0123);
    check(width == 16'h0123, "R6 stopped load", int'(width), 16'h0123);
    @(negedge clk); run = 1'b1;
    measure(STEPS * 8, STEPS * 8, "R4 oversize");
    @(negedge clk); run = 1'b0;

    // R3 other sources
    wr_width(5);  src = 3'd2; @(negedge clk); run = 1'b1;
    measure(STEPS * 32, 5 * 32, "R3 div32");
    @(negedge clk); run = 1'b0;
    wr_width(9);  src = 3'd1; @(negedge clk); run = 1'b1;
    measure(STEPS * 128, 9 * 128, "R3 div128");
    @(negedge clk); run = 1'b0;
    wr_width(3);  src = 3'd0; @(negedge clk); run = 1'b1;
    measure(STEPS * 2048, 3 * 2048, "R3 div2048");
    @(negedge clk); run = 1'b0;
    wr_width(7);  src = 3'd4; @(negedge clk); run = 1'b1;
    measure(STEPS * 5, 7 * 5, "R3 slow");
    @(negedge clk); run = 1'b0;
    src = 3'd5; @(negedge clk); run = 1'b1;
    held = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (irq) held++;
    end
    check(held == 0, "R3 no count code", held, 0);
    @(negedge clk); run = 1'b0;

    // R7 byte sequencing while stopped
    src = 3'd3;
    wr_width(6);
    @(negedge clk); wr_hi = 1'b1; wdata = 8'h01;
    @(negedge clk); wr_hi = 1'b0;
    @(negedge clk);
    check(width == 16'd6, "R7 lone high byte", int'(width), 6);
    @(negedge clk); wr_lo = 1'b1; wdata = 8'd9;
    @(negedge clk); wr_lo = 1'b0;
    @(negedge clk);
    check(width == 16'd6, "R7 lone low byte", int'(width), 6);
    @(negedge clk); wr_hi = 1'b1; wdata = 8'h00;
    @(negedge clk); wr_hi = 1'b0;
    check(width == 16'd9, "R7 pair completes", int'(width), 9);

    // R5 buffered update while running
    wr_width(3);
    @(negedge clk); run = 1'b1;
    wait_irq("R5");
    repeat (20) @(negedge clk);
    wr_width(11);
    check(width == 16'd3, "R5 readback old", int'(width), 3);
    wait_irq("R5");
    check(width == 16'd11, "R5 transfer at pulse", int'(width), 11);
    measure(STEPS * 8, 11 * 8, "R5");

    // R11 commit on the wrap edge
    repeat (STEPS * 8 - 2) @(negedge clk);
    wr_lo = 1'b1; wdata = 8'd2;
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = 8'd0;
    @(negedge clk); wr_hi = 1'b0;
    check(irq == 1'b1, "R11 aligned to wrap", int'(irq), 1);
    check(width == 16'd11, "R11 not taken at same wrap", int'(width), 11);
    wait_irq("R11");
    check(width == 16'd2, "R11 taken at next wrap", int'(width), 2);
    @(negedge clk); run = 1'b0;

    // R8 stop holds the pin
    wr_width(5);
    @(negedge clk); run = 1'b1;
    wait_irq("R8");
    repeat (37) @(negedge clk);
    p0 = pwm;
    run = 1'b0;
    check(p0 == 1'b1, "R8 level at stop", int'(p0), 1);
    held = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pwm != p0 || irq) held++;
    end
    check(held == 0, "R8 frozen while stopped", held, 0);

    // R9 polarity force and inverted waveform
    @(negedge clk); tff_wr = 1'b1; tff = 1'b1;
    @(negedge clk); tff_wr = 1'b0;
    check(pwm == 1'b0, "R9 force low", int'(pwm), 0);
    @(negedge clk); tff_wr = 1'b1; tff = 1'b0;
    @(negedge clk); tff_wr = 1'b0;
    check(pwm == 1'b1, "R9 force high", int'(pwm), 1);
    @(negedge clk); tff_wr = 1'b1; tff = 1'b1;
    @(negedge clk); tff_wr = 1'b0;
    run = 1'b1;
    measure(STEPS * 8, (STEPS - 5) * 8, "R9 inverted");

    // R10 polarity write while running is ignored
    @(negedge clk); tff_wr = 1'b1; tff = 1'b0;
    @(negedge clk); tff_wr = 1'b0;
    measure(STEPS * 8, (STEPS - 5) * 8, "R10");
    @(negedge clk); run = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule